// File: doc/BRIEF.md
# Windowed Core Select Controller

This block lets one host access window reach any of several cores that sit on an on-chip backplane. The window can show one core at a time. A register access arrives on a request/acknowledge port. It carries a core index, an offset inside that core's region, an access width (byte, halfword or word), a direction and write data. If the addressed core is already showing in the window, the access goes straight out on the window port.

If a different core is addressed, the controller moves the window first. It writes a new window base through a configuration-register port. It then reads that register back and converts the value into a core index. If the index does not match the request, it waits a fixed 10 µs and tries again. After too many attempts, or if the configuration port reports an error, the access fails. A failed read returns all ones at the access width. A failed write is dropped.

The block keeps a record of which core is mapped. That record is set only after a switch has been confirmed, and it is cleared as soon as a switch begins.

Top module: `core_window_ctrl`

## Requirements
- R1: Every window-base write carries ENUM_BASE + index × 2^REGION_LOG2 for the requested core index.
- R2: A switch succeeds only when (readback − ENUM_BASE) >> REGION_LOG2 equals the requested index. The access then goes to the window port with its offset, width code, direction and write data unchanged. Read data returns masked to the width, with zeros above: size code 0 is a byte, 1 a halfword, 2 or 3 a word.
- R3: After a readback mismatch, the configuration port stays idle for exactly CLK_HZ/100000 cycles (at least one). Then the same base is written again.
- R4: A switch succeeds if any of its first MAX_RETRIES+2 write/readback attempts matches. After MAX_RETRIES+2 mismatching attempts it is abandoned.
- R5: An access to the core already recorded as mapped produces no configuration traffic.
- R6: A failed switch sets the error flag with the acknowledge. A failed read returns 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1 and 2. A failed write makes no window access and returns zero data.
- R7: An error response from the configuration port, on either the write or the readback, ends the switch at once with a failure and no further attempt.
- R8: After any failed switch no core is recorded as mapped. The next access always switches, even to the core that was mapped before.
- R9: After reset the acknowledge, configuration request and window request are low and no core is mapped.
- R10: The configuration and window requests are never high together. The acknowledge lasts one cycle. A configuration request holds its command until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access request, held until acc_ack |
| acc_core | input | CORE_W | Target core index |
| acc_off | input | REGION_LOG2 | Offset inside the core region |
| acc_size | input | 2 | Width code: 0 byte, 1 halfword, 2/3 word |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| acc_ack | output | 1 | One-cycle completion pulse |
| acc_err | output | 1 | Access failed (valid with acc_ack) |
| acc_rdata | output | 32 | Read data (valid with acc_ack) |
| cfg_req | output | 1 | Window-register access request |
| cfg_we | output | 1 | 1 = write window base, 0 = read back |
| cfg_wdata | output | 32 | Window base to write |
| cfg_ack | input | 1 | Configuration access done |
| cfg_err | input | 1 | Configuration access failed (with cfg_ack) |
| cfg_rdata | input | 32 | Readback of the window register |
| win_req | output | 1 | Window access request |
| win_we | output | 1 | Window access direction |
| win_off | output | REGION_LOG2 | Window offset |
| win_size | output | 2 | Window access width code |
| win_wdata | output | 32 | Window write data |
| win_ack | input | 1 | Window access done |
| win_rdata | input | 32 | Window read data |

## Verification
The bench builds the block with MAX_RETRIES = 2 and CLK_HZ = 600000. The retry wait is then six cycles, so the exact idle gap is easy to count, and the full limit of four attempts is reached in a short run. Its configuration model can corrupt any number of readbacks or return an error on a chosen write or read. This exercises the last-chance success, abandonment after the limit, and immediate error exit. With eight cores and 4 KiB regions, the window model can check on every clock that a window access only happens while the register decodes to the requested core.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_SW   = 2'd1,
    T_ACC  = 2'd2
  } top_st_e;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_WR   = 2'd1,
    SW_RD   = 2'd2,
    SW_WAIT = 2'd3
  } sw_st_e;

  // Width code to lane mask: 0 byte, 1 halfword, otherwise word.
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cwc_wait_timer.sv
module cwc_wait_timer #(
  parameter int CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= CW'(CYCLES - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);

  // R3
  tmr_idle_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !run);

endmodule

// File: rtl/cwc_switch.sv
module cwc_switch
  import cwc_pkg::*;
#(
  parameter int          CORE_W      = 4,
  parameter int          REGION_LOG2 = 12,
  parameter logic [31:0] ENUM_BASE   = 32'h1800_0000,
  parameter int          MAX_RETRIES = 10,
  parameter int          WAIT_CYC    = 1250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CORE_W-1:0] core,
  output logic              done,
  output logic              ok,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_ack,
  input  logic              cfg_err,
  input  logic [31:0]       cfg_rdata
);
  localparam int ATT_W = $clog2(MAX_RETRIES + 3);

  sw_st_e            st;
  logic [CORE_W-1:0] tgt;
  logic [ATT_W-1:0]  att;
  logic [31:0]       rb_idx;
  logic              rb_match;
  logic              out_of_tries;
  logic              tmr_load;
  logic              tmr_done;

  function automatic logic [31:0] win_base(input logic [CORE_W-1:0] c);
    win_base = ENUM_BASE + (32'(c) << REGION_LOG2);
  endfunction

  assign rb_idx       = (cfg_rdata - ENUM_BASE) >> REGION_LOG2;
  assign rb_match     = (rb_idx == 32'(tgt));
  assign out_of_tries = (att > ATT_W'(MAX_RETRIES));
  assign tmr_load     = (st == SW_RD) && cfg_ack && !cfg_err && !rb_match && !out_of_tries;

  cwc_wait_timer #(.CYCLES(WAIT_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .done (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SW_IDLE;
      tgt       <= '0;
      att       <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_wdata <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SW_IDLE: begin
          if (start) begin
            tgt       <= core;
            att       <= '0;
            cfg_req   <= 1'b1;
            cfg_we    <= 1'b1;
            cfg_wdata <= win_base(core);
            st        <= SW_WR;
          end
        end
        SW_WR: begin
          if (cfg_ack) begin
            if (cfg_err) begin
              cfg_req <= 1'b0;
              done    <= 1'b1;
              ok      <= 1'b0;
              st      <= SW_IDLE;
            end else begin
              cfg_we <= 1'b0;
              st     <= SW_RD;
            end
          end
        end
        SW_RD: begin
          if (cfg_ack) begin
            cfg_req <= 1'b0;
            if (cfg_err) begin
              done <= 1'b1;
              ok   <= 1'b0;
              st   <= SW_IDLE;
            end else if (rb_match) begin
              done <= 1'b1;
              ok   <= 1'b1;
              st   <= SW_IDLE;
            end else if (out_of_tries) begin
              done <= 1'b1;
              ok   <= 1'b0;
              st   <= SW_IDLE;
            end else begin
              att <= att + 1'b1;
              st  <= SW_WAIT;
            end
          end
        end
        SW_WAIT: begin
          if (tmr_done) begin
            cfg_req <= 1'b1;
            cfg_we  <= 1'b1;
            st      <= SW_WR;
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  // R1
  base_value_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_we) |-> (((cfg_wdata - ENUM_BASE) >> REGION_LOG2) == 32'(tgt)));

  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SW_WAIT) |-> !cfg_req);

  // R7
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_ack && cfg_err) |=> (done && !ok && !cfg_req));

  // R4
  att_bound_chk: assert property (@(posedge clk) disable iff (rst)
    att <= ATT_W'(MAX_RETRIES + 1));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_we) && $stable(cfg_wdata)));

endmodule

// File: rtl/cwc_resp_fmt.sv
module cwc_resp_fmt
  import cwc_pkg::*;
(
  input  logic        fail,
  input  logic        is_wr,
  input  logic [1:0]  size,
  input  logic [31:0] raw,
  output logic [31:0] data
);
  always_comb begin
    if (is_wr)     data = 32'h0;
    else if (fail) data = size_mask(size);
    else           data = raw & size_mask(size);
  end
endmodule

// File: rtl/core_window_ctrl.sv
module core_window_ctrl
  import cwc_pkg::*;
#(
  parameter int          N_CORES     = 16,
  parameter int          REGION_LOG2 = 12,
  parameter logic [31:0] ENUM_BASE   = 32'h1800_0000,
  parameter int          MAX_RETRIES = 10,
  parameter int          CLK_HZ      = 125_000_000,
  localparam int         CORE_W      = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int         OFF_W       = REGION_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic [CORE_W-1:0] acc_core,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [1:0]        acc_size,
  input  logic              acc_we,
  input  logic [31:0]       acc_wdata,
  output logic              acc_ack,
  output logic              acc_err,
  output logic [31:0]       acc_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_ack,
  input  logic              cfg_err,
  input  logic [31:0]       cfg_rdata,
  output logic              win_req,
  output logic              win_we,
  output logic [OFF_W-1:0]  win_off,
  output logic [1:0]        win_size,
  output logic [31:0]       win_wdata,
  input  logic              win_ack,
  input  logic [31:0]       win_rdata
);
  localparam int WAIT_RAW = CLK_HZ / 100_000;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  top_st_e           st;
  logic [CORE_W-1:0] l_core;
  logic [CORE_W-1:0] map_core;
  logic              map_vld;
  logic              sw_start;
  logic              sw_done;
  logic              sw_ok;
  logic              fmt_fail;
  logic [31:0]       fmt_data;
  logic              hit;

  assign hit      = map_vld && (map_core == acc_core);
  assign fmt_fail = (st == T_SW);

  cwc_switch #(
    .CORE_W      (CORE_W),
    .REGION_LOG2 (REGION_LOG2),
    .ENUM_BASE   (ENUM_BASE),
    .MAX_RETRIES (MAX_RETRIES),
    .WAIT_CYC    (WAIT_CYC)
  ) u_switch (
    .clk       (clk),
    .rst       (rst),
    .start     (sw_start),
    .core      (l_core),
    .done      (sw_done),
    .ok        (sw_ok),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_ack   (cfg_ack),
    .cfg_err   (cfg_err),
    .cfg_rdata (cfg_rdata)
  );

  cwc_resp_fmt u_fmt (
    .fail  (fmt_fail),
    .is_wr (win_we),
    .size  (win_size),
    .raw   (win_rdata),
    .data  (fmt_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      l_core    <= '0;
      map_core  <= '0;
      map_vld   <= 1'b0;
      sw_start  <= 1'b0;
      win_req   <= 1'b0;
      win_we    <= 1'b0;
      win_off   <= '0;
      win_size  <= 2'd0;
      win_wdata <= '0;
      acc_ack   <= 1'b0;
      acc_err   <= 1'b0;
      acc_rdata <= '0;
    end else begin
      sw_start <= 1'b0;
      acc_ack  <= 1'b0;
      case (st)
        T_IDLE: begin
          if (acc_req && !acc_ack) begin
            l_core    <= acc_core;
            win_we    <= acc_we;
            win_off   <= acc_off;
            win_size  <= acc_size;
            win_wdata <= acc_wdata;
            if (hit) begin
              win_req <= 1'b1;
              st      <= T_ACC;
            end else begin
              map_vld  <= 1'b0;
              sw_start <= 1'b1;
              st       <= T_SW;
            end
          end
        end
        T_SW: begin
          if (sw_done) begin
            if (sw_ok) begin
              map_core <= l_core;
              map_vld  <= 1'b1;
              win_req  <= 1'b1;
              st       <= T_ACC;
            end else begin
              acc_ack   <= 1'b1;
              acc_err   <= 1'b1;
              acc_rdata <= fmt_data;
              st        <= T_IDLE;
            end
          end
        end
        T_ACC: begin
          if (win_ack) begin
            win_req   <= 1'b0;
            acc_ack   <= 1'b1;
            acc_err   <= 1'b0;
            acc_rdata <= fmt_data;
            st        <= T_IDLE;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R10
  one_owner_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req && win_req));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ack |=> !acc_ack);

  // R5
  win_mapped_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(win_req) |-> (map_vld && (map_core == l_core)));

  // R8
  fail_unmaps_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ack && acc_err) |-> !map_vld);

  // R6
  fail_no_win_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_done && !sw_ok) |=> !win_req);

endmodule

// File: tb/core_window_ctrl_bench.sv
module core_window_ctrl_bench;
  localparam int          NC     = 8;
  localparam int          LOG2   = 12;
  localparam logic [31:0] BASE   = 32'h1800_0000;
  localparam int          MAXR   = 2;
  localparam int          HZ     = 600_000;
  localparam int          WAITC  = 6;
  localparam logic [31:0] REGION = 32'h1 << LOG2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_req = 1'b0;
  logic [2:0]  acc_core = '0;
  logic [11:0] acc_off = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_we = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic        acc_ack, acc_err;
  logic [31:0] acc_rdata;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0, cfg_err = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        win_req, win_we;
  logic [11:0] win_off;
  logic [1:0]  win_size;
  logic [31:0] win_wdata;
  logic        win_ack = 1'b0;
  logic [31:0] win_rdata = '0;

  always #4 clk = ~clk;

  core_window_ctrl #(
    .N_CORES(NC), .REGION_LOG2(LOG2), .ENUM_BASE(BASE),
    .MAX_RETRIES(MAXR), .CLK_HZ(HZ)
  ) u_core_window_ctrl (
    .clk(clk), .rst(rst),
    .acc_req(acc_req), .acc_core(acc_core), .acc_off(acc_off), .acc_size(acc_size),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_ack(acc_ack), .acc_err(acc_err),
    .acc_rdata(acc_rdata),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
    .cfg_err(cfg_err), .cfg_rdata(cfg_rdata),
    .win_req(win_req), .win_we(win_we), .win_off(win_off), .win_size(win_size),
    .win_wdata(win_wdata), .win_ack(win_ack), .win_rdata(win_rdata)
  );

  int checks = 0, failures = 0, mon_fail = 0;
  bit finished = 0;

  // Reference world state
  logic [31:0] cfg_reg = '0;
  int cur_core = 0, mis_left = 0;
  bit inj_wr_err = 0, inj_rd_err = 0;
  int cfg_pend = 0, win_pend = 0, cyc = 0, rd_cyc = 0;
  bit gap_armed = 0;
  int gaps[$];
  int wr_cnt = 0, wr_bad = 0, win_cnt = 0;
  logic        log_we;
  logic [11:0] log_off;
  logic [1:0]  log_size;
  logic [31:0] log_wdata;

  function automatic logic [31:0] pat(input int c, input int o);
    return 32'h5A00_0000 | (32'(c) << 16) | 32'(o);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock reference: config register, core windows, overlap monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      cfg_ack = 1'b0; cfg_err = 1'b0; win_ack = 1'b0;
      if (!rst) begin
        if (cfg_req && win_req) begin
          mon_fail++;
          $display("FAIL R10 overlap actual=1 expected=0");
        end
        if (cfg_req) begin
          if (cfg_pend == 0 && cfg_we && gap_armed) begin
            gaps.push_back(cyc - rd_cyc - 1);
            gap_armed = 0;
          end
          if (cfg_pend == 0) cfg_pend = 1;
          else begin
            cfg_pend = 0;
            cfg_ack = 1'b1;
            if (cfg_we) begin
              wr_cnt++;
              if (cfg_wdata != BASE + 32'(cur_core) * REGION) wr_bad++;
              if (inj_wr_err) begin cfg_err = 1'b1; inj_wr_err = 0; end
              else cfg_reg = cfg_wdata;
            end else begin
              if (inj_rd_err) begin
                cfg_err = 1'b1; inj_rd_err = 0; cfg_rdata = 32'hDEAD_0000;
              end else if (mis_left > 0) begin
                cfg_rdata = cfg_reg + REGION;
                mis_left--;
                rd_cyc = cyc;
                gap_armed = 1;
              end else cfg_rdata = cfg_reg;
            end
          end
        end
        if (win_req) begin
          if (((cfg_reg - BASE) >> LOG2) != 32'(cur_core)) begin
            mon_fail++;
            $display("FAIL R2 window decodes actual=%0d expected=%0d",
                     (cfg_reg - BASE) >> LOG2, cur_core);
          end
          if (win_pend == 0) win_pend = 1;
          else begin
            win_pend = 0;
            win_ack = 1'b1;
            win_cnt++;
            log_we = win_we; log_off = win_off; log_size = win_size; log_wdata = win_wdata;
            win_rdata = pat(cur_core, int'(win_off));
          end
        end
      end
    end
  end

  int n_wr, n_win;
  logic [31:0] rd;
  bit er;

  task automatic access(input int core, input int off, input int sz, input bit we,
                        input logic [31:0] wd);
    int wr0, win0;
    wr0 = wr_cnt; win0 = win_cnt; wr_bad = 0;
    gaps.delete(); gap_armed = 0;
    cur_core = core;
    @(negedge clk);
    acc_req = 1'b1; acc_core = 3'(core); acc_off = 12'(off);
    acc_size = 2'(sz); acc_we = we; acc_wdata = wd;
    do @(negedge clk); while (!acc_ack);
    rd = acc_rdata; er = acc_err;
    acc_req = 1'b0;
    n_wr = wr_cnt - wr0; n_win = win_cnt - win0;
    @(negedge clk);
    chk("R10 ack one cycle", 32'(acc_ack), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset ack", 32'(acc_ack), 0);
    chk("R9 reset cfg_req", 32'(cfg_req), 0);
    chk("R9 reset win_req", 32'(win_req), 0);

    // First access always switches
    access(3, 'h10, 2, 0, 0);
    chk("R9 first access switches", n_wr, 1);
    chk("R1 base value", wr_bad, 0);
    chk("R2 word read data", rd, pat(3, 'h10));
    chk("R2 no error", 32'(er), 0);

    access(3, 'h21, 0, 0, 0);
    chk("R5 hit no cfg", n_wr, 0);
    chk("R2 byte read", rd, pat(3, 'h21) & 32'hFF);

    access(3, 'h40, 1, 1, 32'h1234_ABCD);
    chk("R5 hit write no cfg", n_wr, 0);
    chk("R2 fwd we", 32'(log_we), 1);
    chk("R2 fwd off", 32'(log_off), 'h40);
    chk("R2 fwd size", 32'(log_size), 1);
    chk("R2 fwd wdata", log_wdata, 32'h1234_ABCD);

    mis_left = 1;
    access(5, 'h8, 2, 0, 0);
    chk("R3 one retry", n_wr, 2);
    chk("R3 wait gap", (gaps.size() > 0) ? gaps[0] : -1, WAITC);
    chk("R1 base on retry", wr_bad, 0);
    chk("R3 success after retry", rd, pat(5, 'h8));

    mis_left = MAXR + 1;
    access(6, 'h2, 1, 0, 0);
    chk("R4 last-chance attempts", n_wr, MAXR + 2);
    chk("R4 last-chance ok", 32'(er), 0);
    chk("R4 half read", rd, pat(6, 'h2) & 32'hFFFF);

    mis_left = 99;
    access(1, 'h4, 2, 0, 0);
    mis_left = 0;
    chk("R4 abandon attempts", n_wr, MAXR + 2);
    chk("R6 fail err", 32'(er), 1);
    chk("R6 fail word ones", rd, 32'hFFFF_FFFF);
    chk("R6 fail no window", n_win, 0);

    access(6, 'h3, 0, 0, 0);
    chk("R8 reswitch after fail", n_wr, 1);
    chk("R8 data", rd, pat(6, 'h3) & 32'hFF);

    inj_wr_err = 1;
    access(2, 'h5, 0, 0, 0);
    chk("R7 write err no retry", n_wr, 1);
    chk("R6 byte ones", rd, 32'hFF);
    chk("R7 err flag", 32'(er), 1);

    inj_rd_err = 1;
    access(4, 'h6, 1, 0, 0);
    chk("R7 readback err no retry", n_wr, 1);
    chk("R6 half ones", rd, 32'hFFFF);

    mis_left = 99;
    access(2, 'h7, 2, 1, 32'hCAFE_F00D);
    mis_left = 0;
    chk("R6 failed write dropped", n_win, 0);
    chk("R6 failed write err", 32'(er), 1);
    chk("R6 failed write data", rd, 0);

    access(7, 'hFFF, 2, 0, 0);
    chk("R8 switch after fail", n_wr, 1);
    chk("R2 top core data", rd, pat(7, 'hFFF));
    access(7, 'h1, 2, 0, 0);
    chk("R5 hit after switch", n_wr, 0);

    chk("R10 R2 monitors", mon_fail, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule